// File: doc/BRIEF.md
# Asynchronous SRAM Bridge

This block lets a clocked system read and write an external 512K x 8 asynchronous static RAM. A client presents one request at a time (valid, write flag, 19-bit address, 8-bit write data). The bridge drives the memory's address bus and its three active-low strobes: chip select, write strobe and output enable. It also drives an output-enable control for the shared bidirectional data bus, which a pad ring or board-level tri-state buffer turns into the real bus. When the request completes, the bridge returns a one-cycle completion strobe, together with the captured byte for a read.

Every analog timing figure of the memory is given as a nanosecond parameter. The bridge turns each figure into a whole number of clock cycles by rounding up against `CLK_PERIOD_NS`. A read holds the strobes for the longest of cycle time, address access and output-enable access. A write pulse covers the pulse width, the address-to-end-of-write time and the data setup. After a read, the bridge inserts an idle turnaround of at least the float time before anything else can follow. During a write, output enable stays high, so the memory's drivers are already off when the bridge starts driving.

Top module: `sram_bridge`

## Requirements
- R1: While `rst_ni` is low and on the first cycle after release, all three strobes are high, `mem_dq_oe_o` is low and `done_o` is low.
- R2: A read holds chip select and output enable low and the write strobe high for RD_CYC cycles, where RD_CYC is the largest of ceil(T_RC_NS/CLK_PERIOD_NS), ceil(T_AA_NS/CLK_PERIOD_NS) and ceil(T_OE_NS/CLK_PERIOD_NS). This is 3 cycles at the defaults. The strobes go low on the clock edge that accepts the request.
- R3: The read byte is sampled from `mem_dq_i` on the edge that ends the last access cycle. `done_o` is high, and `rdata_o` holds that byte, in the cycle that starts RD_CYC edges after the accepting edge.
- R4: A write holds chip select and the write strobe low and output enable high for WR_PULSE cycles. WR_PULSE is the largest of the rounded T_WP_NS, T_AW_NS and T_DW_NS, and is 3 at the defaults. `mem_dq_oe_o` is high only in those cycles.
- R5: The byte on `mem_dq_o` is stable for the whole write pulse, so the memory captures it when the write strobe rises. A later read of the same address returns it, and a second write to that address replaces it.
- R6: `mem_addr_o` changes only on an edge before which chip select and the write strobe were both high. It holds each address for at least ceil(T_WC_NS/CLK_PERIOD_NS) cycles.
- R7: After a read, the strobes stay high for max(1, ceil(T_HZ_NS/CLK_PERIOD_NS)) cycles before the bridge returns to idle. After a write, they stay high for the rounded T_WC_NS minus WR_PULSE cycles, with a minimum of 1.
- R8: A request is accepted only in the idle state. A `req_valid_i` pulse during a busy cycle yields no completion and leaves the memory contents unchanged.
- R9: `done_o` is high for exactly one cycle per accepted request.
- R10: The data bus is never driven while output enable is low or the write strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present (sampled in idle only) |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Word address |
| req_wdata_i | input | DATA_W | Write byte |
| done_o | output | 1 | One-cycle completion strobe |
| rdata_o | output | DATA_W | Read byte, valid with `done_o` after a read |
| mem_addr_o | output | ADDR_W | Memory address bus |
| mem_ce_no | output | 1 | Chip select, active low |
| mem_we_no | output | 1 | Write strobe, active low |
| mem_oe_no | output | 1 | Output enable, active low |
| mem_dq_o | output | DATA_W | Data driven toward the memory |
| mem_dq_oe_o | output | 1 | Drive enable for the data bus |
| mem_dq_i | input | DATA_W | Data returned by the memory |

## Verification
Each result has a fixed cycle. The strobes and the bus drive change on the accepting edge. At the defaults, `done_o` and `rdata_o` are due 3 edges after the accepting edge for both reads and writes. The next request can be accepted 5 edges after the previous one. The bench counts edges itself and computes from the nanosecond parameters the window in which each strobe must be low and the cycle in which `done_o` must rise. It compares every output at each falling edge against that window, so a result that comes one cycle early or late fails. A behavioural memory model beside it returns valid data only once the access time has elapsed. The model also flags any address change under an active strobe, a short write pulse, late data setup, bus contention and a turnaround shorter than the float time.

// File: rtl/sram_bridge_pkg.sv
package sram_bridge_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_RD_TURN,
    ST_WRITE,
    ST_WR_RECOV
  } bridge_state_e;

  // ceil(ns / per); zero stays zero
  function automatic int unsigned ns2cyc(input int unsigned ns, input int unsigned per);
    if (ns == 0) return 0;
    return (ns + per - 1) / per;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_bridge_timer.sv
module sram_bridge_timer #(
  parameter int unsigned CNT_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             last_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= load_val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign last_o = (cnt_q == '0);

endmodule

// File: rtl/sram_bridge_fsm.sv
module sram_bridge_fsm
  import sram_bridge_pkg::*;
#(
  parameter int unsigned RD_CYC   = 3,
  parameter int unsigned RD_TURN  = 1,
  parameter int unsigned WR_PULSE = 3,
  parameter int unsigned WR_RECOV = 1,
  parameter int unsigned CNT_W    = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic             req_write_i,
  input  logic             last_i,
  output bridge_state_e    state_o,
  output logic             load_o,
  output logic [CNT_W-1:0] load_val_o,
  output logic             accept_o,
  output logic             capture_o,
  output logic             done_o
);

  localparam logic [CNT_W-1:0] RD_LOAD  = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] RT_LOAD  = CNT_W'(RD_TURN - 1);
  localparam logic [CNT_W-1:0] WR_LOAD  = CNT_W'(WR_PULSE - 1);
  localparam logic [CNT_W-1:0] WRC_LOAD = CNT_W'(WR_RECOV - 1);

  bridge_state_e state_q, state_d;
  logic          done_q, done_d;

  always_comb begin
    state_d    = state_q;
    load_o     = 1'b0;
    load_val_o = '0;
    accept_o   = 1'b0;
    capture_o  = 1'b0;
    done_d     = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid_i) begin
          accept_o   = 1'b1;
          load_o     = 1'b1;
          load_val_o = req_write_i ? WR_LOAD : RD_LOAD;
          state_d    = req_write_i ? ST_WRITE : ST_READ;
        end
      end
      ST_READ: begin
        if (last_i) begin
          capture_o  = 1'b1;
          done_d     = 1'b1;
          load_o     = 1'b1;
          load_val_o = RT_LOAD;
          state_d    = ST_RD_TURN;
        end
      end
      ST_RD_TURN: begin
        if (last_i) state_d = ST_IDLE;
      end
      ST_WRITE: begin
        if (last_i) begin
          done_d     = 1'b1;
          load_o     = 1'b1;
          load_val_o = WRC_LOAD;
          state_d    = ST_WR_RECOV;
        end
      end
      ST_WR_RECOV: begin
        if (last_i) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  assign state_o = state_q;
  assign done_o  = done_q;

endmodule

// File: rtl/sram_bridge_datapath.sv
module sram_bridge_datapath
  import sram_bridge_pkg::*;
#(
  parameter int unsigned ADDR_W = 19,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  bridge_state_e     state_i,
  input  logic              accept_i,
  input  logic              capture_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_ce_no,
  output logic              mem_we_no,
  output logic              mem_oe_no,
  output logic              mem_dq_oe_o,
  output logic [DATA_W-1:0] rdata_o
);

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;

  // address and write byte move only on acceptance, which happens from idle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept_i) begin
      addr_q  <= req_addr_i;
      wdata_q <= req_wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        rdata_q <= '0;
    else if (capture_i) rdata_q <= mem_dq_i;
  end

  logic is_rd, is_wr;
  assign is_rd = (state_i == ST_READ);
  assign is_wr = (state_i == ST_WRITE);

  assign mem_ce_no   = ~(is_rd | is_wr);
  assign mem_we_no   = ~is_wr;
  assign mem_oe_no   = ~is_rd;
  assign mem_dq_oe_o = is_wr;
  assign mem_addr_o  = addr_q;
  assign mem_dq_o    = wdata_q;
  assign rdata_o     = rdata_q;

endmodule

// File: rtl/sram_bridge.sv
module sram_bridge
  import sram_bridge_pkg::*;
#(
  parameter int unsigned ADDR_W        = 19,
  parameter int unsigned DATA_W        = 8,
  parameter int unsigned CLK_PERIOD_NS = 20,
  parameter int unsigned T_RC_NS       = 55,
  parameter int unsigned T_AA_NS       = 55,
  parameter int unsigned T_OE_NS       = 30,
  parameter int unsigned T_HZ_NS       = 20,
  parameter int unsigned T_WC_NS       = 55,
  parameter int unsigned T_WP_NS       = 45,
  parameter int unsigned T_AW_NS       = 50,
  parameter int unsigned T_DW_NS       = 25
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_ce_no,
  output logic              mem_we_no,
  output logic              mem_oe_no,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe_o,
  input  logic [DATA_W-1:0] mem_dq_i
);

  localparam int unsigned RD_CYC = umax(1, umax(umax(ns2cyc(T_RC_NS, CLK_PERIOD_NS),
                                                     ns2cyc(T_AA_NS, CLK_PERIOD_NS)),
                                                ns2cyc(T_OE_NS, CLK_PERIOD_NS)));
  localparam int unsigned RD_TURN  = umax(1, ns2cyc(T_HZ_NS, CLK_PERIOD_NS));
  localparam int unsigned WR_PULSE = umax(1, umax(umax(ns2cyc(T_WP_NS, CLK_PERIOD_NS),
                                                       ns2cyc(T_AW_NS, CLK_PERIOD_NS)),
                                                  ns2cyc(T_DW_NS, CLK_PERIOD_NS)));
  localparam int unsigned WC_CYC   = ns2cyc(T_WC_NS, CLK_PERIOD_NS);
  localparam int unsigned WR_RECOV = (WC_CYC > WR_PULSE + 1) ? (WC_CYC - WR_PULSE) : 1;
  localparam int unsigned MAX_CNT  = umax(umax(RD_CYC, RD_TURN), umax(WR_PULSE, WR_RECOV));
  localparam int unsigned CNT_W    = $clog2(MAX_CNT + 1);

  bridge_state_e    state;
  logic             load, last, accept, capture;
  logic [CNT_W-1:0] load_val;

  sram_bridge_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (load_val),
    .last_o     (last)
  );

  sram_bridge_fsm #(
    .RD_CYC   (RD_CYC),
    .RD_TURN  (RD_TURN),
    .WR_PULSE (WR_PULSE),
    .WR_RECOV (WR_RECOV),
    .CNT_W    (CNT_W)
  ) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_write_i (req_write_i),
    .last_i      (last),
    .state_o     (state),
    .load_o      (load),
    .load_val_o  (load_val),
    .accept_o    (accept),
    .capture_o   (capture),
    .done_o      (done_o)
  );

  sram_bridge_datapath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_dp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .state_i     (state),
    .accept_i    (accept),
    .capture_i   (capture),
    .req_addr_i  (req_addr_i),
    .req_wdata_i (req_wdata_i),
    .mem_dq_i    (mem_dq_i),
    .mem_addr_o  (mem_addr_o),
    .mem_dq_o    (mem_dq_o),
    .mem_ce_no   (mem_ce_no),
    .mem_we_no   (mem_we_no),
    .mem_oe_no   (mem_oe_no),
    .mem_dq_oe_o (mem_dq_oe_o),
    .rdata_o     (rdata_o)
  );

endmodule

// File: rtl/sram_bridge_chk.sv
module sram_bridge_chk #(
  parameter int unsigned ADDR_W   = 19,
  parameter int unsigned WR_PULSE = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_ce_no,
  input logic              mem_we_no,
  input logic              mem_oe_no,
  input logic              mem_dq_oe_o,
  input logic              done_o
);

  logic [7:0] we_low_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         we_low_q <= '0;
    else if (mem_we_no)                  we_low_q <= '0;
    else if (we_low_q != 8'hff)          we_low_q <= we_low_q + 8'd1;
  end

  // R6
  addr_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mem_addr_o) |-> ($past(mem_ce_no) && $past(mem_we_no)));

  // R10
  bus_no_clash_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_dq_oe_o |-> (mem_oe_no && !mem_we_no && !mem_ce_no));

  // R2
  read_strobes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_oe_no |-> (!mem_ce_no && mem_we_no));

  // R9
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R4
  we_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_we_no) |-> (32'(we_low_q) >= WR_PULSE));

  // R7
  read_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_oe_no) |-> !mem_dq_oe_o);

endmodule

bind sram_bridge sram_bridge_chk #(
  .ADDR_W   (ADDR_W),
  .WR_PULSE (WR_PULSE)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mem_addr_o  (mem_addr_o),
  .mem_ce_no   (mem_ce_no),
  .mem_we_no   (mem_we_no),
  .mem_oe_no   (mem_oe_no),
  .mem_dq_oe_o (mem_dq_oe_o),
  .done_o      (done_o)
);

// File: tb/sram_bridge_tb_top.sv
module sram_bridge_tb_top;

  localparam int PER   = 20;
  localparam int T_RC  = 55, T_AA = 55, T_OE = 30, T_HZ = 20;
  localparam int T_WC  = 55, T_WP = 45, T_AW = 50, T_DW = 25;

  function automatic int cyc_of(input int ns);
    return (ns + PER - 1) / PER;
  endfunction
  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int RD_L = imax(1, imax(imax(cyc_of(T_RC), cyc_of(T_AA)), cyc_of(T_OE)));
  localparam int RD_T = imax(1, cyc_of(T_HZ));
  localparam int WR_L = imax(1, imax(imax(cyc_of(T_WP), cyc_of(T_AW)), cyc_of(T_DW)));
  localparam int WR_T = imax(1, cyc_of(T_WC) - WR_L);

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0, wr = 1'b0;
  logic [18:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        done;
  logic [7:0]  rdata;
  logic [18:0] m_addr;
  logic        m_ce_n, m_we_n, m_oe_n, m_dq_oe;
  logic [7:0]  m_dq_o, m_dq_i;

  always #10 clk = ~clk;

  sram_bridge dut_i (
    .clk_i (clk), .rst_ni (rst_n),
    .req_valid_i (valid), .req_write_i (wr), .req_addr_i (addr), .req_wdata_i (wdata),
    .done_o (done), .rdata_o (rdata),
    .mem_addr_o (m_addr), .mem_ce_no (m_ce_n), .mem_we_no (m_we_n), .mem_oe_no (m_oe_n),
    .mem_dq_o (m_dq_o), .mem_dq_oe_o (m_dq_oe), .mem_dq_i (m_dq_i)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic fail(input string req, input string what, input int act, input int exp);
    errors++;
    $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
  endtask

  // ---------------- behavioural memory model ----------------
  logic [7:0] model_mem [int];
  int rd_cnt = 0, wlow = 0, dstable = 0, since_addr = 100, since_oe = 100;
  logic [18:0] prev_addr = '0;
  logic [18:0] w_addr = '0;
  logic        prev_ce = 1'b1, prev_we = 1'b1, prev_dq_oe = 1'b0;
  logic [7:0]  prev_dq = '0;

  function automatic logic [7:0] mem_get(input logic [18:0] a);
    if (model_mem.exists(int'(a))) return model_mem[int'(a)];
    return 8'h00;
  endfunction

  always @* begin
    if (!m_ce_n && !m_oe_n && m_we_n && ((rd_cnt + 1) * PER >= T_AA))
      m_dq_i = mem_get(m_addr);
    else
      m_dq_i = 8'hEE;
  end

  always @(posedge clk) begin
    if (rst_n) begin
      rd_cnt <= (!m_ce_n && !m_oe_n && m_we_n) ? rd_cnt + 1 : 0;
      if (m_addr !== prev_addr) begin
        if (!(prev_ce && prev_we)) fail("R6", "addr moved under strobe", 0, 1);
        if (since_addr * PER < T_WC) fail("R6", "address hold cycles", since_addr, cyc_of(T_WC));
        since_addr <= 1;
      end else begin
        since_addr <= since_addr + 1;
      end
      if (!m_ce_n && !m_we_n) begin
        wlow    <= wlow + 1;
        dstable <= (wlow > 0 && m_dq_o == prev_dq) ? dstable + 1 : 1;
        w_addr  <= m_addr;
      end else if (wlow > 0) begin
        if (wlow * PER < T_WP || wlow * PER < T_AW) fail("R4", "write pulse cycles", wlow, WR_L);
        if (dstable * PER < T_DW) fail("R5", "data setup cycles", dstable, cyc_of(T_DW));
        model_mem[int'(w_addr)] = prev_dq;
        wlow <= 0;
      end
      if (m_dq_oe && !m_oe_n) fail("R10", "bus clash with output enable", 1, 0);
      if (m_dq_oe && (m_we_n || m_ce_n)) fail("R10", "drive outside write pulse", 1, 0);
      since_oe <= m_oe_n ? since_oe + 1 : 0;
      if (m_dq_oe && !prev_dq_oe && since_oe * PER < T_HZ)
        fail("R7", "turnaround too short", since_oe, RD_T);
      prev_addr  <= m_addr;
      prev_ce    <= m_ce_n;
      prev_we    <= m_we_n;
      prev_dq    <= m_dq_o;
      prev_dq_oe <= m_dq_oe;
    end
  end

  // ---------------- cycle reference model ----------------
  logic [7:0] exp_mem [int];
  int cyc = 0;
  int cur_a = -100, cur_L = 0, free_c = 0;
  bit cur_w = 0;
  logic [7:0] cur_exp = '0;

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      bit act, edone;
      act   = (cyc >= cur_a) && (cyc < cur_a + cur_L);
      edone = (cyc == cur_a + cur_L);
      checks++;
      if (done !== edone) fail("R9", "done_o", done, edone);
      if (m_ce_n !== !act) fail(cur_w ? "R4" : "R2", "ce_n", m_ce_n, !act);
      if (m_we_n !== !(act && cur_w)) fail("R4", "we_n", m_we_n, !(act && cur_w));
      if (m_oe_n !== !(act && !cur_w)) fail("R2", "oe_n", m_oe_n, !(act && !cur_w));
      if (m_dq_oe !== (act && cur_w)) fail("R4", "dq_oe", m_dq_oe, act && cur_w);
      if (edone && !cur_w) begin
        checks++;
        if (rdata !== cur_exp) fail("R3", "read byte", rdata, cur_exp);
      end
    end
  end

  task automatic issue(input bit w, input logic [18:0] a, input logic [7:0] d);
    @(negedge clk);
    while (cyc < free_c) @(negedge clk);
    valid = 1'b1; wr = w; addr = a; wdata = d;
    cur_a  = cyc + 1;
    cur_w  = w;
    cur_L  = w ? WR_L : RD_L;
    free_c = cur_a + cur_L + (w ? WR_T : RD_T);
    if (w) exp_mem[int'(a)] = d;
    else   cur_exp = exp_mem.exists(int'(a)) ? exp_mem[int'(a)] : 8'h00;
    @(negedge clk);
    valid = 1'b0;
  endtask

  // R8: one-cycle request while busy must be dropped
  task automatic poke_busy(input logic [18:0] a, input logic [7:0] d);
    valid = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fail("WDOG", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    checks++;
    if ({m_ce_n, m_we_n, m_oe_n, m_dq_oe, done} !== 5'b11100)
      fail("R1", "reset outputs", {m_ce_n, m_we_n, m_oe_n, m_dq_oe, done}, 5'b11100);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if ({m_ce_n, m_we_n, m_oe_n, m_dq_oe, done} !== 5'b11100)
      fail("R1", "post-reset outputs", {m_ce_n, m_we_n, m_oe_n, m_dq_oe, done}, 5'b11100);

    // R5 basic writes incl. both address extremes
    issue(1'b1, 19'h00000, 8'h11);
    issue(1'b1, 19'h7FFFF, 8'h5A);
    issue(1'b0, 19'h00000, 8'h00);   // R3
    issue(1'b0, 19'h7FFFF, 8'h00);   // R3
    issue(1'b0, 19'h12345, 8'h00);   // unwritten reads zero
    // alternating patterns
    issue(1'b1, 19'h2AAAA, 8'hA5);
    issue(1'b1, 19'h55555, 8'h3C);
    issue(1'b0, 19'h2AAAA, 8'h00);
    issue(1'b0, 19'h55555, 8'h00);
    // R5 overwrite
    issue(1'b1, 19'h2AAAA, 8'hC3);
    issue(1'b0, 19'h2AAAA, 8'h00);
    // R8 busy pokes during a read and during a write
    issue(1'b0, 19'h55555, 8'h00);
    poke_busy(19'h00100, 8'h77);
    issue(1'b1, 19'h00200, 8'h99);
    poke_busy(19'h00100, 8'h66);
    issue(1'b0, 19'h00100, 8'h00);   // R8 expects untouched 0x00
    issue(1'b0, 19'h00200, 8'h00);
    // R7 back-to-back read then write then read, same address
    issue(1'b0, 19'h00200, 8'h00);
    issue(1'b1, 19'h00200, 8'h0F);
    issue(1'b0, 19'h00200, 8'h00);
    for (int i = 0; i < 8; i++) issue(1'b1, 19'(i * 19'h0F0F1), 8'(i * 37 + 1));
    for (int i = 7; i >= 0; i--) issue(1'b0, 19'(i * 19'h0F0F1), 8'h00);
    while (cyc < free_c + 3) @(negedge clk);
    finish_run();
  end

endmodule